// File: doc/BRIEF.md
# Waveform Synthesizer Command Sequencer

This block sits on the host side of a serially programmed waveform synthesizer. It takes one high-level command at a time on a valid/ready interface and turns it into the exact series of 16-bit command words the synthesizer expects. It then shifts each word out on a write-only SPI link with an active-low chip select. The commands are: full initialisation, load a frequency register, load a phase register, pick the active frequency or phase register, set the sign-output mode, and set the wave shape.

Mode-type settings live in one control word inside the synthesizer, and that word cannot be read back. The block therefore keeps a shadow copy of it. Each register-select, sign-output or wave-shape command changes only its own bits of the shadow copy and then sends the whole updated copy. Multi-word commands are expanded in a fixed order. A frequency load, for example, is a prefix word followed by the low and high 14-bit halves of a 28-bit value.

The command opcode is `cmd_op`: 0 initialise, 1 frequency load, 2 phase load, 3 frequency select, 4 phase select, 5 sign output, 6 wave shape, 7 reserved. `cmd_sel` chooses register 0 or 1, and `cmd_data` carries the value or mode code.

Top module: `dds_cmd_seq`

## Requirements
- R1: Each word is framed by exactly one low period of `spi_cs_n` containing exactly 16 falling edges of `spi_sclk`. Bits go most significant first. `spi_sclk` idles high whenever `spi_cs_n` is high. `spi_mosi` is set up before each falling edge and changes only while `spi_sclk` is high, so it is stable for as long as `spi_sclk` stays low.
- R2: Between two frames, `spi_cs_n` stays high for at least one full SPI clock period, which is 2*HALF_DIV system clocks.
- R3: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. For any command that sends words, `cmd_ready` is low from the next cycle until the last frame of the sequence has ended, and it is low whenever `spi_cs_n` is low.
- R4: A frequency load (op 1) sends three words in this order: 0x2000, then ADDR | data[13:0], then ADDR | data[27:14]. ADDR is 0x4000 when `cmd_sel`=0 and 0x8000 when `cmd_sel`=1.
- R5: A phase load (op 2) sends one word: 0xC000 | data[11:0] when `cmd_sel`=0, or 0xE000 | data[11:0] when `cmd_sel`=1. Data bits above 11 are dropped.
- R6: Initialisation (op 0) first sets bit 0x0100 in the shadow word and sends the shadow twice. It then zeroes frequency register 0 (0x2000, 0x4000, 0x4000), zeroes frequency register 1 (0x2000, 0x8000, 0x8000), and zeroes phase registers 0 and 1 (0xC000, 0xE000). Last, it clears 0x0100 and sends the shadow: 11 words in total.
- R7: A frequency select (op 3) sets shadow bit 0x0800 for `cmd_sel`=1 and clears it for 0. A phase select (op 4) does the same with bit 0x0400. In both cases the whole updated shadow word is then sent.
- R8: A sign-output command (op 5) clears mask 0x003A in the shadow word and ORs in a code chosen by data[1:0]: 0 gives 0x0000, 1 gives 0x0028, 2 gives 0x0020, 3 gives 0x0038. The shadow word is then sent.
- R9: A wave-shape command (op 6) with data[0]=1 (triangle) clears mask 0x003A and sets 0x0002. With data[0]=0 (sine) it clears only 0x0002. The shadow word is then sent.
- R10: After reset the shadow control word is 0x0000.
- R11: While in reset and right after it, `spi_cs_n` and `spi_sclk` are high and `cmd_ready` is high.
- R12: The reserved opcode 7 is accepted without sending any frame and leaves the shadow word unchanged. `cmd_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer can accept a command |
| cmd_op | input | 3 | Command opcode |
| cmd_sel | input | 1 | Target register 0 or 1 |
| cmd_data | input | 28 | Frequency, phase or mode code |
| spi_sclk | output | 1 | SPI clock, idles high |
| spi_mosi | output | 1 | SPI serial data out |
| spi_cs_n | output | 1 | Active-low chip select, one frame per word |

## Verification
The checker watches the link on every cycle. It checks that the SPI clock idles high outside frames, that data holds steady while the clock is low, that chip select rises only with the clock high, that the gap between frames meets its minimum, and that `cmd_ready` is never high during a frame. Word content cannot be seen by those per-cycle rules. The order of words in each sequence, the values in the shadow word across a series of read-modify-write commands, and the no-effect behaviour of the reserved opcode can only be shown by the bench's scenarios. The bench decodes each frame with its own SPI receiver and compares it against a shadow model it keeps itself.

// File: rtl/dds_seq_pkg.sv
package dds_seq_pkg;

  localparam int CW_W    = 16;
  localparam int VAL_W   = 28;
  localparam int HALF_W  = 14;
  localparam int PHASE_W = 12;
  localparam int STEP_W  = 4;

  typedef enum logic [2:0] {
    OP_INIT      = 3'd0,
    OP_FREQ      = 3'd1,
    OP_PHASE     = 3'd2,
    OP_SEL_FREQ  = 3'd3,
    OP_SEL_PHASE = 3'd4,
    OP_SIGN      = 3'd5,
    OP_WAVE      = 3'd6,
    OP_RSVD      = 3'd7
  } dds_op_e;

  localparam logic [CW_W-1:0] CW_RESET     = 16'h0100;
  localparam logic [CW_W-1:0] CW_FSEL      = 16'h0800;
  localparam logic [CW_W-1:0] CW_PSEL      = 16'h0400;
  localparam logic [CW_W-1:0] CW_SIGN_MASK = 16'h003A;
  localparam logic [CW_W-1:0] CW_TRI       = 16'h0002;
  localparam logic [CW_W-1:0] W_FREQ_PFX   = 16'h2000;
  localparam logic [CW_W-1:0] A_FREQ0      = 16'h4000;
  localparam logic [CW_W-1:0] A_FREQ1      = 16'h8000;
  localparam logic [CW_W-1:0] A_PHASE0     = 16'hC000;
  localparam logic [CW_W-1:0] A_PHASE1     = 16'hE000;

  localparam logic [STEP_W-1:0] INIT_LAST = 4'd10;
  localparam logic [STEP_W-1:0] FREQ_LAST = 4'd2;

  function automatic logic [CW_W-1:0] sign_code(input logic [1:0] c);
    case (c)
      2'd1:    sign_code = 16'h0028;
      2'd2:    sign_code = 16'h0020;
      2'd3:    sign_code = 16'h0038;
      default: sign_code = 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/dds_spi_tx.sv
module dds_spi_tx #(
  parameter int WORD_W     = 16,
  parameter int HALF_DIV   = 2,
  parameter int GAP_HALVES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n,
  output logic              done
);

  localparam int HALF_LAST = 2 * WORD_W + GAP_HALVES;
  localparam int HC_W      = $clog2(HALF_LAST + 1);
  localparam int DIV_W     = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic              busy_q, busy_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [HC_W-1:0]   hcnt_q, hcnt_d;
  logic [WORD_W-1:0] sreg_q, sreg_d;
  logic              sclk_q, sclk_d;
  logic              cs_n_q, cs_n_d;
  logic              mosi_q, mosi_d;
  logic              done_q, done_d;
  logic              tick;

  assign tick = busy_q && (div_q == DIV_W'(HALF_DIV - 1));

  always_comb begin
    busy_d = busy_q;
    div_d  = div_q;
    hcnt_d = hcnt_q;
    sreg_d = sreg_q;
    done_d = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        div_d  = '0;
        hcnt_d = '0;
        sreg_d = word;
      end
    end else begin
      div_d = tick ? '0 : div_q + 1'b1;
      if (tick) begin
        if (hcnt_q == HC_W'(HALF_LAST)) begin
          busy_d = 1'b0;
          done_d = 1'b1;
          hcnt_d = '0;
        end else begin
          hcnt_d = hcnt_q + 1'b1;
          // data moves on the rising edge that ends a low half
          if (hcnt_q[0] && (hcnt_q < HC_W'(2 * WORD_W - 1))) begin
            sreg_d = {sreg_q[WORD_W-2:0], 1'b0};
          end
        end
      end
    end
    sclk_d = !(busy_d && hcnt_d[0] && (hcnt_d < HC_W'(2 * WORD_W)));
    cs_n_d = !(busy_d && (hcnt_d <= HC_W'(2 * WORD_W)));
    mosi_d = busy_d ? sreg_d[WORD_W-1] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      div_q  <= '0;
      hcnt_q <= '0;
      sreg_q <= '0;
      sclk_q <= 1'b1;
      cs_n_q <= 1'b1;
      mosi_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      div_q  <= div_d;
      hcnt_q <= hcnt_d;
      sreg_q <= sreg_d;
      sclk_q <= sclk_d;
      cs_n_q <= cs_n_d;
      mosi_q <= mosi_d;
      done_q <= done_d;
    end
  end

  assign sclk = sclk_q;
  assign mosi = mosi_q;
  assign cs_n = cs_n_q;
  assign done = done_q;

endmodule

// File: rtl/dds_word_gen.sv
module dds_word_gen
  import dds_seq_pkg::*;
(
  input  dds_op_e           op,
  input  logic              sel,
  input  logic [VAL_W-1:0]  data,
  input  logic [CW_W-1:0]   shadow,
  input  logic [STEP_W-1:0] step,
  output logic [CW_W-1:0]   word,
  output logic              last
);

  logic [CW_W-1:0] f_addr;
  logic [CW_W-1:0] p_addr;

  assign f_addr = sel ? A_FREQ1 : A_FREQ0;
  assign p_addr = sel ? A_PHASE1 : A_PHASE0;

  always_comb begin
    word = shadow;
    last = 1'b1;
    case (op)
      OP_INIT: begin
        last = (step == INIT_LAST);
        case (step)
          4'd0, 4'd1: word = shadow;
          4'd2, 4'd5: word = W_FREQ_PFX;
          4'd3, 4'd4: word = A_FREQ0;
          4'd6, 4'd7: word = A_FREQ1;
          4'd8:       word = A_PHASE0;
          4'd9:       word = A_PHASE1;
          default:    word = shadow & ~CW_RESET;
        endcase
      end
      OP_FREQ: begin
        last = (step == FREQ_LAST);
        case (step)
          4'd0:    word = W_FREQ_PFX;
          4'd1:    word = f_addr | {{(CW_W-HALF_W){1'b0}}, data[HALF_W-1:0]};
          default: word = f_addr | {{(CW_W-HALF_W){1'b0}}, data[VAL_W-1:HALF_W]};
        endcase
      end
      OP_PHASE: word = p_addr | {{(CW_W-PHASE_W){1'b0}}, data[PHASE_W-1:0]};
      default:  word = shadow;
    endcase
  end

endmodule

// File: rtl/dds_cmd_seq.sv
module dds_cmd_seq
  import dds_seq_pkg::*;
#(
  parameter int HALF_DIV   = 2,
  parameter int GAP_HALVES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [2:0]  cmd_op,
  input  logic        cmd_sel,
  input  logic [27:0] cmd_data,
  output logic        spi_sclk,
  output logic        spi_mosi,
  output logic        spi_cs_n
);

  typedef enum logic [1:0] {ST_IDLE, ST_LAUNCH, ST_WAIT} st_e;

  st_e               st_q, st_d;
  dds_op_e           op_q, op_d;
  logic              sel_q, sel_d;
  logic [VAL_W-1:0]  data_q, data_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [CW_W-1:0]   shadow_q, shadow_d;
  logic              accept;
  logic [CW_W-1:0]   tx_word;
  logic              tx_last;
  logic              tx_done;
  logic              tx_start;
  dds_op_e           in_op;

  assign in_op     = dds_op_e'(cmd_op);
  assign cmd_ready = (st_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign tx_start  = (st_q == ST_LAUNCH);

  function automatic logic [CW_W-1:0] shadow_rmw(input dds_op_e o, input logic s,
                                                 input logic [VAL_W-1:0] d,
                                                 input logic [CW_W-1:0] cw);
    case (o)
      OP_INIT:      shadow_rmw = cw | CW_RESET;
      OP_SEL_FREQ:  shadow_rmw = s ? (cw | CW_FSEL) : (cw & ~CW_FSEL);
      OP_SEL_PHASE: shadow_rmw = s ? (cw | CW_PSEL) : (cw & ~CW_PSEL);
      OP_SIGN:      shadow_rmw = (cw & ~CW_SIGN_MASK) | sign_code(d[1:0]);
      OP_WAVE:      shadow_rmw = d[0] ? ((cw & ~CW_SIGN_MASK) | CW_TRI) : (cw & ~CW_TRI);
      default:      shadow_rmw = cw;
    endcase
  endfunction

  always_comb begin
    st_d     = st_q;
    op_d     = op_q;
    sel_d    = sel_q;
    data_d   = data_q;
    step_d   = step_q;
    shadow_d = shadow_q;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          op_d     = in_op;
          sel_d    = cmd_sel;
          data_d   = cmd_data;
          step_d   = '0;
          shadow_d = shadow_rmw(in_op, cmd_sel, cmd_data, shadow_q);
          if (in_op != OP_RSVD) st_d = ST_LAUNCH;
        end
      end
      ST_LAUNCH: st_d = ST_WAIT;
      default: begin
        if (tx_done) begin
          if (tx_last) begin
            st_d = ST_IDLE;
            if (op_q == OP_INIT) shadow_d = shadow_q & ~CW_RESET;
          end else begin
            step_d = step_q + 1'b1;
            st_d   = ST_LAUNCH;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      op_q     <= OP_RSVD;
      sel_q    <= 1'b0;
      data_q   <= '0;
      step_q   <= '0;
      shadow_q <= '0;
    end else begin
      st_q     <= st_d;
      op_q     <= op_d;
      sel_q    <= sel_d;
      data_q   <= data_d;
      step_q   <= step_d;
      shadow_q <= shadow_d;
    end
  end

  dds_word_gen u_gen (
    .op     (op_q),
    .sel    (sel_q),
    .data   (data_q),
    .shadow (shadow_q),
    .step   (step_q),
    .word   (tx_word),
    .last   (tx_last)
  );

  dds_spi_tx #(
    .WORD_W     (CW_W),
    .HALF_DIV   (HALF_DIV),
    .GAP_HALVES (GAP_HALVES)
  ) u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tx_start),
    .word  (tx_word),
    .sclk  (spi_sclk),
    .mosi  (spi_mosi),
    .cs_n  (spi_cs_n),
    .done  (tx_done)
  );

endmodule

// File: rtl/dds_cmd_seq_chk.sv
module dds_cmd_seq_chk #(
  parameter int HALF_DIV = 2
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_ready,
  input logic spi_sclk,
  input logic spi_mosi,
  input logic spi_cs_n
);

  localparam int GAP_MIN = 2 * HALF_DIV;
  localparam int GC_W    = $clog2(GAP_MIN + 2);

  logic [GC_W-1:0] gap_q;

  // cycles chip select has been high; saturates, starts saturated after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= GC_W'(GAP_MIN + 1);
    end else if (!spi_cs_n) begin
      gap_q <= '0;
    end else if (gap_q < GC_W'(GAP_MIN + 1)) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  p_clk_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> spi_sclk);

  p_mosi_hold_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_sclk && !$past(spi_sclk)) |-> $stable(spi_mosi));

  p_cs_rise_clk_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> spi_sclk);

  p_frame_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> (gap_q >= GC_W'(GAP_MIN)));

  p_ready_low_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> !cmd_ready);

endmodule

bind dds_cmd_seq dds_cmd_seq_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .spi_sclk  (spi_sclk),
  .spi_mosi  (spi_mosi),
  .spi_cs_n  (spi_cs_n)
);

// File: tb/tb_dds_cmd_seq.sv
module tb_dds_cmd_seq;

  localparam int HALF = 2;

  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [2:0]  cmd_op;
  logic        cmd_sel;
  logic [27:0] cmd_data;
  logic        spi_sclk;
  logic        spi_mosi;
  logic        spi_cs_n;

  int n_chk;
  int n_bad;
  logic [15:0] rx_q[$];
  logic [15:0] exp_q[$];
  logic [15:0] sh_model;
  logic [15:0] rx_sh;
  int          rx_bits;
  int          bad_frames;
  int          bad_gaps;
  time         t_rise;
  bit          have_rise;

  dds_cmd_seq #(.HALF_DIV(HALF)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_sel   (cmd_sel),
    .cmd_data  (cmd_data),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi),
    .spi_cs_n  (spi_cs_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // independent SPI receiver: mode 2, sample on the falling edge
  always @(negedge spi_sclk) begin
    if (rst_n && spi_cs_n === 1'b0) begin
      rx_sh   = {rx_sh[14:0], spi_mosi};
      rx_bits = rx_bits + 1;
    end
  end

  always @(posedge spi_cs_n) begin
    if (rst_n && rx_bits > 0) begin
      if (rx_bits != 16) bad_frames = bad_frames + 1;
      rx_q.push_back(rx_sh);
      rx_bits = 0;
      t_rise = $time;
      have_rise = 1'b1;
    end
  end

  always @(negedge spi_cs_n) begin
    if (rst_n && have_rise && ($time - t_rise) < time'(2 * HALF * 20)) bad_gaps = bad_gaps + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // issue one command, check ready drops (R3), wait for the link to go quiet
  task automatic issue(input logic [2:0] op, input logic sel, input logic [27:0] d,
                       input bit sends);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_sel   = sel;
    cmd_data  = d;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (sends) check("R3 ready low after accept", {31'd0, cmd_ready}, 32'd0);
    else       check("R12 ready stays high", {31'd0, cmd_ready}, 32'd1);
    while (!(cmd_ready && spi_cs_n)) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic compare_words(input string req);
    check({req, " word count"}, rx_q.size(), exp_q.size());
    while (exp_q.size() > 0 && rx_q.size() > 0) begin
      check(req, {16'd0, rx_q.pop_front()}, {16'd0, exp_q.pop_front()});
    end
    rx_q.delete();
    exp_q.delete();
  endtask

  task automatic t_reset_state();
    check("R11 cs_n idle", {31'd0, spi_cs_n}, 32'd1);
    check("R11 sclk idle", {31'd0, spi_sclk}, 32'd1);
    check("R11 ready", {31'd0, cmd_ready}, 32'd1);
  endtask

  task automatic t_first_select();
    // R10: shadow is zero, so only the phase-select bit shows
    sh_model = 16'h0000 | 16'h0400;
    exp_q.push_back(sh_model);
    issue(3'd4, 1'b1, 28'd0, 1'b1);
    compare_words("R10 R7 phase select after reset");
  endtask

  task automatic t_init();
    sh_model = sh_model | 16'h0100;
    exp_q.push_back(sh_model);
    exp_q.push_back(sh_model);
    exp_q.push_back(16'h2000); exp_q.push_back(16'h4000); exp_q.push_back(16'h4000);
    exp_q.push_back(16'h2000); exp_q.push_back(16'h8000); exp_q.push_back(16'h8000);
    exp_q.push_back(16'hC000); exp_q.push_back(16'hE000);
    sh_model = sh_model & ~16'h0100;
    exp_q.push_back(sh_model);
    issue(3'd0, 1'b0, 28'd0, 1'b1);
    compare_words("R6 init sequence");
  endtask

  task automatic t_freq(input logic sel, input logic [27:0] d);
    logic [15:0] a;
    a = sel ? 16'h8000 : 16'h4000;
    exp_q.push_back(16'h2000);
    exp_q.push_back(a | {2'b00, d[13:0]});
    exp_q.push_back(a | {2'b00, d[27:14]});
    issue(3'd1, sel, d, 1'b1);
    compare_words("R4 frequency load");
  endtask

  task automatic t_phase(input logic sel, input logic [27:0] d);
    exp_q.push_back((sel ? 16'hE000 : 16'hC000) | {4'h0, d[11:0]});
    issue(3'd2, sel, d, 1'b1);
    compare_words("R5 phase load");
  endtask

  task automatic t_sel_freq(input logic sel);
    sh_model = sel ? (sh_model | 16'h0800) : (sh_model & ~16'h0800);
    exp_q.push_back(sh_model);
    issue(3'd3, sel, 28'd0, 1'b1);
    compare_words("R7 frequency select");
  endtask

  task automatic t_sign(input logic [1:0] c);
    logic [15:0] code;
    case (c)
      2'd1: code = 16'h0028;
      2'd2: code = 16'h0020;
      2'd3: code = 16'h0038;
      default: code = 16'h0000;
    endcase
    sh_model = (sh_model & ~16'h003A) | code;
    exp_q.push_back(sh_model);
    issue(3'd5, 1'b0, {26'd0, c}, 1'b1);
    compare_words("R8 sign output");
  endtask

  task automatic t_wave(input logic tri_mode);
    sh_model = tri_mode ? ((sh_model & ~16'h003A) | 16'h0002) : (sh_model & ~16'h0002);
    exp_q.push_back(sh_model);
    issue(3'd6, 1'b0, {27'd0, tri_mode}, 1'b1);
    compare_words("R9 wave shape");
  endtask

  task automatic t_reserved();
    issue(3'd7, 1'b1, 28'hFFFFFFF, 1'b0);
    check("R12 no frame", rx_q.size(), 32'd0);
    rx_q.delete();
    // shadow must be untouched: a select exposes the whole word
    t_sel_freq(1'b1);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; bad_frames = 0; bad_gaps = 0;
    rx_bits = 0; rx_sh = '0; have_rise = 1'b0; t_rise = 0;
    sh_model = '0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_sel = 1'b0; cmd_data = '0;
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_first_select();
    t_init();
    t_freq(1'b0, 28'd16777216);
    t_freq(1'b1, 28'hABCDEF1);
    t_phase(1'b0, 28'h0000123);
    t_phase(1'b1, 28'h000FFFF);
    t_sel_freq(1'b1);
    t_sel_freq(1'b0);
    t_sign(2'd1);
    t_sign(2'd3);
    t_wave(1'b1);
    t_sign(2'd2);
    t_wave(1'b0);
    t_sign(2'd1);
    t_wave(1'b0);
    t_wave(1'b1);
    t_sign(2'd0);
    t_reserved();
    check("R1 frame bit count", bad_frames, 32'd0);
    check("R2 inter-frame gap", bad_gaps, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk = n_chk + 1;
    n_bad = n_bad + 1;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule